// File: doc/BRIEF.md
# Shadow Region Address Remapper

This block sits at the front of a memory controller and classifies each address arriving from the system bus. An address below a configured DRAM ceiling is real memory and leaves unchanged. An address above it is looked up against a small table of shadow-region descriptors. When a descriptor claims the address, the block rewrites it into a pseudo-virtual address. A later stage, not part of this block, turns that pseudo-virtual address into a DRAM location.

Each descriptor chooses one of three rewrite rules. A linear rule adds a fixed displacement. A strided rule spreads dense shadow elements apart by a power-of-two pitch. A gather rule reads an index from an in-memory vector and scales that index by the pitch. Because every size is a power of two, the scaling is done with shifts and no divider is needed. Software loads descriptors through a write port. Addresses enter through a valid/ready handshake. Results leave as a one-cycle valid pulse that carries a translated flag and an error flag. Vector entries are fetched through a simple request/response port.

Top module: `shadow_addr_mapper`

## Requirements
- R1: An accepted address below `DRAM_LIMIT` produces `out_valid` on the next cycle with `out_addr` equal to the input address, `out_translated`=0 and `out_error`=0.
- R2: Mode code 0 (linear). A shadow address A with region base B (B <= A < limit L, L exclusive) yields `out_addr` = PV + (A - B) one cycle after acceptance, with `out_translated`=1.
- R3: Mode code 1 (strided). With offset O = A - B, element size 2^E and pitch 2^S, the block yields PV + floor(O / 2^E) * 2^S + (O mod 2^E) one cycle after acceptance.
- R4: Mode code 2 (gather). One cycle after acceptance, `vec_req` pulses for exactly one cycle with `vec_addr` = VB + floor(O / 2^E) * 4, since vector entries are 4 bytes. The cycle after `vec_rsp_valid`, the block gives PV + D * 2^S + (O mod 2^E), where D is `vec_rsp_data`.
- R5: While a gather waits for its vector entry, `in_ready` is 0 and no new address is accepted. `in_ready` returns to 1 in the cycle in which the result is presented.
- R6: An address at or above `DRAM_LIMIT` that no enabled descriptor claims, or that is claimed by a descriptor holding mode code 3, produces `out_valid` with `out_error`=1, `out_translated`=0 and `out_addr`=0 one cycle after acceptance.
- R7: When enabled regions overlap, the descriptor with the lowest index is used.
- R8: On a configuration write, the low `PAGE_LOG2` bits of shadow base, shadow limit and pseudo-virtual base are cleared. The vector base is stored as written.
- R9: After reset every descriptor is disabled, `in_ready`=1, and `out_valid` and `vec_req` are 0.
- R10: A `vec_rsp_valid` pulse that arrives when no gather is pending produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | SEL_W | Descriptor index to write |
| cfg_enable | input | 1 | Descriptor enable |
| cfg_mode | input | 2 | Rewrite rule: 0 linear, 1 strided, 2 gather, 3 reserved |
| cfg_shadow_base | input | ADDR_W | First shadow address of the region |
| cfg_shadow_limit | input | ADDR_W | Exclusive end of the region |
| cfg_pv_base | input | ADDR_W | Pseudo-virtual start of the target structure |
| cfg_vec_base | input | ADDR_W | Address of the index vector (gather) |
| cfg_stride_log2 | input | SH_W | log2 of the pitch in bytes |
| cfg_elem_log2 | input | SH_W | log2 of the element size in bytes |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address can be taken |
| in_addr | input | ADDR_W | Bus physical address |
| out_valid | output | 1 | Result pulse |
| out_addr | output | ADDR_W | Passed or rewritten address |
| out_translated | output | 1 | 1 when the address was rewritten |
| out_error | output | 1 | 1 when a shadow address had no usable descriptor |
| vec_req | output | 1 | Vector entry read request |
| vec_addr | output | ADDR_W | Vector entry address |
| vec_rsp_valid | input | 1 | Vector entry returned |
| vec_rsp_data | input | ADDR_W | Vector entry value |

## Verification
The bench probes the limits of each region: the exact base, the last byte, and the exclusive limit, which must give an error. A limit compare that is off by one would translate that limit address. Strided and gather tests use elements wider than one byte with a nonzero byte offset. A design that dropped the low bits, or shifted the whole offset, would return an address off by some bytes. The bench keeps an address valid during a gather stall and sends a stray vector response while idle. A design that accepted during the wait, or reacted to the stray response, would produce extra or corrupted results. Overlapping regions and unaligned configuration writes expose a wrong priority order and a missing page clear.

// File: rtl/smap_pkg.sv
package smap_pkg;
  typedef enum logic [1:0] {
    MAP_LINEAR = 2'd0,
    MAP_STRIDE = 2'd1,
    MAP_GATHER = 2'd2,
    MAP_RSVD   = 2'd3
  } map_mode_e;

  typedef enum logic {
    FSM_IDLE = 1'b0,
    FSM_WAIT = 1'b1
  } map_fsm_e;
endpackage

// File: rtl/smap_desc_table.sv
module smap_desc_table #(
  parameter int ADDR_W    = 32,
  parameter int SH_W      = 5,
  parameter int NUM_DESC  = 4,
  parameter int PAGE_LOG2 = 12,
  parameter int SEL_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic                  cfg_enable,
  input  logic [1:0]            cfg_mode,
  input  logic [ADDR_W-1:0]     cfg_shadow_base,
  input  logic [ADDR_W-1:0]     cfg_shadow_limit,
  input  logic [ADDR_W-1:0]     cfg_pv_base,
  input  logic [ADDR_W-1:0]     cfg_vec_base,
  input  logic [SH_W-1:0]       cfg_stride_log2,
  input  logic [SH_W-1:0]       cfg_elem_log2,
  output logic                  tb_en    [NUM_DESC],
  output smap_pkg::map_mode_e   tb_mode  [NUM_DESC],
  output logic [ADDR_W-1:0]     tb_sbase [NUM_DESC],
  output logic [ADDR_W-1:0]     tb_slim  [NUM_DESC],
  output logic [ADDR_W-1:0]     tb_pv    [NUM_DESC],
  output logic [ADDR_W-1:0]     tb_vb    [NUM_DESC],
  output logic [SH_W-1:0]       tb_st    [NUM_DESC],
  output logic [SH_W-1:0]       tb_el    [NUM_DESC]
);
  import smap_pkg::*;

  localparam logic [ADDR_W-1:0] PAGE_KEEP = {ADDR_W{1'b1}} << PAGE_LOG2;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    logic sel_hit;
    assign sel_hit = cfg_we && (cfg_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        tb_en[g]    <= 1'b0;
        tb_mode[g]  <= MAP_RSVD;
        tb_sbase[g] <= '0;
        tb_slim[g]  <= '0;
        tb_pv[g]    <= '0;
        tb_vb[g]    <= '0;
        tb_st[g]    <= '0;
        tb_el[g]    <= '0;
      end else if (sel_hit) begin
        tb_en[g]    <= cfg_enable;
        tb_mode[g]  <= map_mode_e'(cfg_mode);
        tb_sbase[g] <= cfg_shadow_base & PAGE_KEEP;
        tb_slim[g]  <= cfg_shadow_limit & PAGE_KEEP;
        tb_pv[g]    <= cfg_pv_base & PAGE_KEEP;
        tb_vb[g]    <= cfg_vec_base;
        tb_st[g]    <= cfg_stride_log2;
        tb_el[g]    <= cfg_elem_log2;
      end
    end

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (tb_pv[g] & ~PAGE_KEEP) == '0 && (tb_sbase[g] & ~PAGE_KEEP) == '0); // R8

    AST_RESET_DISABLED: assert property (@(posedge clk)
      $past(rst) |-> !tb_en[g]); // R9
  end
endmodule

// File: rtl/smap_match.sv
module smap_match #(
  parameter int ADDR_W   = 32,
  parameter int NUM_DESC = 4,
  parameter int SEL_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en    [NUM_DESC],
  input  logic [ADDR_W-1:0] sbase [NUM_DESC],
  input  logic [ADDR_W-1:0] slim  [NUM_DESC],
  output logic              hit,
  output logic [SEL_W-1:0]  hit_idx
);
  logic [NUM_DESC-1:0] cand;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_cmp
    assign cand[g] = en[g] && (addr >= sbase[g]) && (addr < slim[g]);
  end

  // Lowest index wins: scan downward so the last assignment is the smallest.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_DESC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/smap_addr_gen.sv
module smap_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int SH_W     = 5,
  parameter int VEC_LOG2 = 2
) (
  input  smap_pkg::map_mode_e mode,
  input  logic [ADDR_W-1:0]   offset,
  input  logic [ADDR_W-1:0]   pv_base,
  input  logic [ADDR_W-1:0]   vec_base,
  input  logic [SH_W-1:0]     st_log2,
  input  logic [SH_W-1:0]     el_log2,
  output logic [ADDR_W-1:0]   lin_addr,
  output logic [ADDR_W-1:0]   vec_addr,
  output logic [ADDR_W-1:0]   byte_off
);
  import smap_pkg::*;

  logic [ADDR_W-1:0] elem_idx;
  logic [ADDR_W-1:0] low_mask;

  assign low_mask = ~({ADDR_W{1'b1}} << el_log2);
  assign elem_idx = offset >> el_log2;
  assign byte_off = offset & low_mask;
  assign vec_addr = vec_base + (elem_idx << VEC_LOG2);

  always_comb begin
    case (mode)
      MAP_STRIDE: lin_addr = pv_base + (elem_idx << st_log2) + byte_off;
      default:    lin_addr = pv_base + offset;
    endcase
  end
endmodule

// File: rtl/shadow_addr_mapper.sv
module shadow_addr_mapper #(
  parameter int              ADDR_W     = 32,
  parameter int              SH_W       = 5,
  parameter int              NUM_DESC   = 4,
  parameter int              PAGE_LOG2  = 12,
  parameter int              VEC_LOG2   = 2,
  parameter logic [31:0]     DRAM_LIMIT = 32'h4000_0000,
  parameter int              SEL_W      = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_shadow_base,
  input  logic [ADDR_W-1:0] cfg_shadow_limit,
  input  logic [ADDR_W-1:0] cfg_pv_base,
  input  logic [ADDR_W-1:0] cfg_vec_base,
  input  logic [SH_W-1:0]   cfg_stride_log2,
  input  logic [SH_W-1:0]   cfg_elem_log2,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_translated,
  output logic              out_error,
  output logic              vec_req,
  output logic [ADDR_W-1:0] vec_addr,
  input  logic              vec_rsp_valid,
  input  logic [ADDR_W-1:0] vec_rsp_data
);
  import smap_pkg::*;

  localparam logic [ADDR_W-1:0] DRAM_TOP = ADDR_W'(DRAM_LIMIT);

  logic              d_en    [NUM_DESC];
  map_mode_e         d_mode  [NUM_DESC];
  logic [ADDR_W-1:0] d_sbase [NUM_DESC];
  logic [ADDR_W-1:0] d_slim  [NUM_DESC];
  logic [ADDR_W-1:0] d_pv    [NUM_DESC];
  logic [ADDR_W-1:0] d_vb    [NUM_DESC];
  logic [SH_W-1:0]   d_st    [NUM_DESC];
  logic [SH_W-1:0]   d_el    [NUM_DESC];

  smap_desc_table #(
    .ADDR_W(ADDR_W), .SH_W(SH_W), .NUM_DESC(NUM_DESC),
    .PAGE_LOG2(PAGE_LOG2), .SEL_W(SEL_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_shadow_base(cfg_shadow_base),
    .cfg_shadow_limit(cfg_shadow_limit), .cfg_pv_base(cfg_pv_base),
    .cfg_vec_base(cfg_vec_base), .cfg_stride_log2(cfg_stride_log2),
    .cfg_elem_log2(cfg_elem_log2),
    .tb_en(d_en), .tb_mode(d_mode), .tb_sbase(d_sbase), .tb_slim(d_slim),
    .tb_pv(d_pv), .tb_vb(d_vb), .tb_st(d_st), .tb_el(d_el)
  );

  logic             hit;
  logic [SEL_W-1:0] hit_idx;

  smap_match #(.ADDR_W(ADDR_W), .NUM_DESC(NUM_DESC), .SEL_W(SEL_W)) u_match (
    .addr(in_addr), .en(d_en), .sbase(d_sbase), .slim(d_slim),
    .hit(hit), .hit_idx(hit_idx)
  );

  map_mode_e         sel_mode;
  logic [ADDR_W-1:0] sel_offset;
  logic [ADDR_W-1:0] gen_lin;
  logic [ADDR_W-1:0] gen_vec;
  logic [ADDR_W-1:0] gen_byte;

  assign sel_mode   = d_mode[hit_idx];
  assign sel_offset = in_addr - d_sbase[hit_idx];

  smap_addr_gen #(.ADDR_W(ADDR_W), .SH_W(SH_W), .VEC_LOG2(VEC_LOG2)) u_gen (
    .mode(sel_mode), .offset(sel_offset), .pv_base(d_pv[hit_idx]),
    .vec_base(d_vb[hit_idx]), .st_log2(d_st[hit_idx]), .el_log2(d_el[hit_idx]),
    .lin_addr(gen_lin), .vec_addr(gen_vec), .byte_off(gen_byte)
  );

  map_fsm_e          state;
  logic [ADDR_W-1:0] pend_pv;
  logic [SH_W-1:0]   pend_st;
  logic [ADDR_W-1:0] pend_byte;
  logic              accept;
  logic              is_dram;

  assign in_ready = (state == FSM_IDLE);
  assign accept   = in_valid && in_ready;
  assign is_dram  = in_addr < DRAM_TOP;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= FSM_IDLE;
      out_valid      <= 1'b0;
      out_addr       <= '0;
      out_translated <= 1'b0;
      out_error      <= 1'b0;
      vec_req        <= 1'b0;
      vec_addr       <= '0;
      pend_pv        <= '0;
      pend_st        <= '0;
      pend_byte      <= '0;
    end else begin
      out_valid <= 1'b0;
      vec_req   <= 1'b0;
      case (state)
        FSM_IDLE: begin
          if (accept) begin
            if (is_dram) begin
              out_valid      <= 1'b1;
              out_addr       <= in_addr;
              out_translated <= 1'b0;
              out_error      <= 1'b0;
            end else if (!hit || sel_mode == MAP_RSVD) begin
              out_valid      <= 1'b1;
              out_addr       <= '0;
              out_translated <= 1'b0;
              out_error      <= 1'b1;
            end else if (sel_mode == MAP_GATHER) begin
              state     <= FSM_WAIT;
              vec_req   <= 1'b1;
              vec_addr  <= gen_vec;
              pend_pv   <= d_pv[hit_idx];
              pend_st   <= d_st[hit_idx];
              pend_byte <= gen_byte;
            end else begin
              out_valid      <= 1'b1;
              out_addr       <= gen_lin;
              out_translated <= 1'b1;
              out_error      <= 1'b0;
            end
          end
        end
        FSM_WAIT: begin
          if (vec_rsp_valid) begin
            state          <= FSM_IDLE;
            out_valid      <= 1'b1;
            out_addr       <= pend_pv + (vec_rsp_data << pend_st) + pend_byte;
            out_translated <= 1'b1;
            out_error      <= 1'b0;
          end
        end
        default: state <= FSM_IDLE;
      endcase
    end
  end

  AST_DRAM_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_addr < DRAM_TOP) |=>
      (out_valid && !out_translated && !out_error && out_addr == $past(in_addr))); // R1

  AST_VREQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req); // R4

  AST_RSP_GIVES_OUT: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && vec_rsp_valid) |=> (out_valid && out_translated && in_ready)); // R4

  AST_STALL_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> !in_ready); // R5

  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_error) |-> (!out_translated && out_addr == '0)); // R6

  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid && vec_rsp_valid) |=> !out_valid); // R10
endmodule

// File: tb/shadow_addr_mapper_test.sv
module shadow_addr_mapper_test;
  localparam int          AW   = 32;
  localparam int          SW   = 5;
  localparam int          ND   = 4;
  localparam logic [31:0] DLIM = 32'h4000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic          cfg_enable = 1'b0;
  logic [1:0]    cfg_mode = '0;
  logic [AW-1:0] cfg_shadow_base = '0, cfg_shadow_limit = '0;
  logic [AW-1:0] cfg_pv_base = '0, cfg_vec_base = '0;
  logic [SW-1:0] cfg_stride_log2 = '0, cfg_elem_log2 = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid, out_translated, out_error, vec_req;
  logic [AW-1:0] out_addr, vec_addr;
  logic          vec_rsp_valid = 1'b0;
  logic [AW-1:0] vec_rsp_data = '0;

  always #5 clk = ~clk;

  shadow_addr_mapper #(.ADDR_W(AW), .SH_W(SW), .NUM_DESC(ND), .DRAM_LIMIT(DLIM)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_shadow_base(cfg_shadow_base),
    .cfg_shadow_limit(cfg_shadow_limit), .cfg_pv_base(cfg_pv_base),
    .cfg_vec_base(cfg_vec_base), .cfg_stride_log2(cfg_stride_log2),
    .cfg_elem_log2(cfg_elem_log2), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_translated(out_translated), .out_error(out_error), .vec_req(vec_req),
    .vec_addr(vec_addr), .vec_rsp_valid(vec_rsp_valid), .vec_rsp_data(vec_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_en [ND];
  int          m_mode [ND];
  logic [31:0] m_sb [ND], m_sl [ND], m_pv [ND], m_vb [ND];
  int          m_st [ND], m_el [ND];
  bit          m_busy;
  logic [31:0] m_ppv, m_pbo;
  int          m_pst;
  bit          e_valid, e_tr, e_err, e_vreq;
  logic [31:0] e_addr, e_vaddr;
  string       e_tag;
  int          hit;
  logic [31:0] off, eidx, bo;

  function automatic logic [31:0] pg(input logic [31:0] x);
    return (x / 32'd4096) * 32'd4096;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; e_valid <= 0; e_vreq <= 0; e_tag <= "R9";
      for (int i = 0; i < ND; i++) m_en[i] <= 0;
    end else begin
      e_valid <= 0;
      e_vreq  <= 0;
      if (in_valid && !m_busy) begin
        if (in_addr < DLIM) begin
          e_valid <= 1; e_addr <= in_addr; e_tr <= 0; e_err <= 0; e_tag <= "R1";
        end else begin
          hit = -1;
          for (int i = 0; i < ND; i++)
            if (hit < 0 && m_en[i] && in_addr >= m_sb[i] && in_addr < m_sl[i]) hit = i;
          if (hit < 0 || m_mode[hit] == 3) begin
            e_valid <= 1; e_addr <= 0; e_tr <= 0; e_err <= 1; e_tag <= "R6";
          end else begin
            off  = in_addr - m_sb[hit];
            eidx = off / (32'd1 << m_el[hit]);
            bo   = off % (32'd1 << m_el[hit]);
            if (m_mode[hit] == 0) begin
              e_valid <= 1; e_addr <= m_pv[hit] + off; e_tr <= 1; e_err <= 0; e_tag <= "R2";
            end else if (m_mode[hit] == 1) begin
              e_valid <= 1; e_addr <= m_pv[hit] + eidx * (32'd1 << m_st[hit]) + bo;
              e_tr <= 1; e_err <= 0; e_tag <= "R3";
            end else begin
              m_busy <= 1; e_vreq <= 1; e_vaddr <= m_vb[hit] + eidx * 32'd4;
              m_ppv <= m_pv[hit]; m_pst <= m_st[hit]; m_pbo <= bo; e_tag <= "R4";
            end
          end
        end
      end
      if (m_busy && vec_rsp_valid) begin
        m_busy <= 0; e_valid <= 1; e_tr <= 1; e_err <= 0; e_tag <= "R4";
        e_addr <= m_ppv + vec_rsp_data * (32'd1 << m_pst) + m_pbo;
      end
      if (cfg_we) begin
        m_en[cfg_sel] <= cfg_enable; m_mode[cfg_sel] <= int'(cfg_mode);
        m_sb[cfg_sel] <= pg(cfg_shadow_base); m_sl[cfg_sel] <= pg(cfg_shadow_limit);
        m_pv[cfg_sel] <= pg(cfg_pv_base); m_vb[cfg_sel] <= cfg_vec_base;
        m_st[cfg_sel] <= int'(cfg_stride_log2); m_el[cfg_sel] <= int'(cfg_elem_log2);
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({e_tag, " out_valid"}, 32'(out_valid), 32'(e_valid));
      if (e_valid && out_valid) begin
        chk({e_tag, " out_addr"}, out_addr, e_addr);
        chk({e_tag, " out_translated"}, 32'(out_translated), 32'(e_tr));
        chk({e_tag, " out_error"}, 32'(out_error), 32'(e_err));
      end
      chk("R4 vec_req", 32'(vec_req), 32'(e_vreq));
      if (e_vreq && vec_req) chk("R4 vec_addr", vec_addr, e_vaddr);
      chk("R5 in_ready", 32'(in_ready), 32'(!m_busy));
    end
  end

  // ---------------- vector memory responder ----------------
  int          rsp_lat = 1;
  int          rsp_cnt = 0;
  logic [31:0] rsp_a;
  bit          stray_req = 0;

  function automatic logic [31:0] vec_val(input logic [31:0] a);
    return ((a >> 2) & 32'h3F) + 32'd3;
  endfunction

  always @(negedge clk) begin
    vec_rsp_valid = 1'b0;
    if (rst) rsp_cnt = 0;
    else begin
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin vec_rsp_valid = 1'b1; vec_rsp_data = vec_val(rsp_a); end
      end
      if (vec_req) begin rsp_a = vec_addr; rsp_cnt = rsp_lat; end
      if (stray_req) begin vec_rsp_valid = 1'b1; vec_rsp_data = 32'h55; stray_req = 0; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg(input int idx, input bit en, input int mode, input logic [31:0] sb,
                     input logic [31:0] sl, input logic [31:0] pv, input logic [31:0] vb,
                     input int st, input int el);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(idx); cfg_enable = en; cfg_mode = 2'(mode);
    cfg_shadow_base = sb; cfg_shadow_limit = sl; cfg_pv_base = pv; cfg_vec_base = vb;
    cfg_stride_log2 = SW'(st); cfg_elem_log2 = SW'(el);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_addr = a;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_out();
    int n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset in_ready", 32'(in_ready), 32'd1);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset vec_req", 32'(vec_req), 32'd0);

    // R1 DRAM bypass at both ends
    send(32'h0000_0000);
    chk("R1 low dram", out_addr, 32'h0000_0000);
    send(DLIM - 1);
    chk("R1 top dram", out_addr, DLIM - 1);
    // R6 no descriptor at all
    send(DLIM);
    chk("R6 unclaimed", 32'(out_error), 32'd1);

    // linear, strided, gather, reserved
    cfg(0, 1, 0, 32'h8000_0000, 32'h8000_1000, 32'h0010_0000, 0, 0, 0);
    cfg(1, 1, 1, 32'h9000_0000, 32'h9001_0000, 32'h0020_0000, 0, 10, 2);
    cfg(2, 1, 2, 32'hA000_0000, 32'hA000_1000, 32'h0040_0000, 32'h0050_0000, 6, 3);
    cfg(3, 1, 3, 32'hB000_0000, 32'hB000_1000, 32'h0060_0000, 0, 0, 0);

    send(32'h8000_0000); chk("R2 region base", out_addr, 32'h0010_0000);
    send(32'h8000_0FFF); chk("R2 last byte", out_addr, 32'h0010_0FFF);
    send(32'h8000_1000); chk("R6 limit exclusive", 32'(out_error), 32'd1);
    send(32'h9000_0014); chk("R3 elem5", out_addr, 32'h0020_1400);
    send(32'h9000_0017); chk("R3 elem5 byte3", out_addr, 32'h0020_1403);
    send(32'hB000_0004); chk("R6 reserved mode", 32'(out_error), 32'd1);

    // gather with latency 1 and 3, input held valid during the stall
    rsp_lat = 1;
    send(32'hA000_0015);
    wait_out();
    chk("R4 gather lat1", out_addr, 32'h0040_0000 + vec_val(32'h0050_0008) * 64 + 5);
    rsp_lat = 3;
    @(negedge clk);
    in_valid = 1; in_addr = 32'hA000_0040;
    @(negedge clk);
    in_addr = 32'h8000_0100;
    repeat (6) @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);

    // R10 stray response while idle
    stray_req = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 stray response", 32'(out_valid), 32'd0);

    // R7 overlap priority
    cfg(3, 1, 0, 32'h8000_0000, 32'h8000_1000, 32'h0070_0000, 0, 0, 0);
    send(32'h8000_0020); chk("R7 lowest index", out_addr, 32'h0010_0020);
    cfg(0, 0, 0, 32'h8000_0000, 32'h8000_1000, 32'h0010_0000, 0, 0, 0);
    send(32'h8000_0020); chk("R7 fallback index", out_addr, 32'h0070_0020);

    // R8 page clear on configuration
    cfg(0, 1, 0, 32'h8000_0456, 32'h8000_1789, 32'h0010_0123, 0, 0, 0);
    send(32'h8000_0010); chk("R8 aligned bases", out_addr, 32'h0010_0010);

    // randomised traffic checked by the per-cycle model
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      rsp_lat = 1 + int'($urandom % 4);
      if ($urandom % 20 == 0) begin
        automatic int k = int'($urandom % ND);
        cfg_we = 1; cfg_sel = 2'(k); cfg_enable = ($urandom % 4) != 0;
        cfg_mode = 2'($urandom % 4);
        cfg_shadow_base = 32'h8000_0000 + 32'(k) * 32'h1000_0000;
        cfg_shadow_limit = cfg_shadow_base + 32'h1000 * (1 + ($urandom % 2));
        cfg_pv_base = 32'h0100_0000 * 32'(k + 1) + ($urandom % 32'h10_0000);
        cfg_vec_base = 32'h0600_0000 + 32'(k) * 32'h100;
        cfg_stride_log2 = SW'($urandom % 9); cfg_elem_log2 = SW'($urandom % 4);
      end else cfg_we = 0;
      in_valid = ($urandom % 3) != 0;
      case ($urandom % 6)
        0: in_addr = $urandom % DLIM;
        5: in_addr = DLIM + ($urandom % 32'h1000_0000);
        default: in_addr = 32'h8000_0000 + 32'($urandom % 4) * 32'h1000_0000 + ($urandom % 32'h2400);
      endcase
    end
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    repeat (10) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule